// File: doc/BRIEF.md
# LCD Raster Timing Generator

This block produces the horizontal and vertical raster timing for a flat panel (LCD channel) or a television encoder (TV channel). Software writes the active size, the totals, the back-porch offsets and the sync widths through a small write port. The block then drives hsync, vsync, data-enable, the current pixel and line position, a field flag and an early start-of-frame pulse. The lead of that pulse is derived from the vertical blanking.

All timing is measured from the start of sync. Pixel 0 of a line is the first hsync pixel, and line 0 of a field is the first vsync line. Active video starts at the programmed back-porch offset, which counts the sync width plus the back porch. On the TV channel the vertical counter advances every half line. This lets progressive timing be programmed in half-lines. It also lets an odd half-line total in interlaced mode shift the second field, and its vsync, by half a line.

New register values go into a shadow bank. They move to the live bank only at a field boundary, so a frame in flight is never torn. While the generator is disabled, the live bank follows the shadow bank every cycle.

Top module: `lcd_raster_gen`

## Requirements
- R1: After reset, and whenever the live enable bit is 0, pins_oe_o, hsync_o, vsync_o, de_o, sof_o, field_o, pix_x_o and line_y_o are all 0.
- R2: While enabled, pix_x_o steps by one per clock from 0 to HTOT-1 and then returns to 0. hsync_o is active for pixels 0 to HSW-1.
- R3: de_o is 1 only when the pixel lies in [HBP, HBP+WIDTH) and the vertical unit counter lies in the active window. On the LCD channel that window is lines [VBP, VBP+HEIGHT).
- R4: On the LCD channel (control bit 1 = 0), line_y_o counts 0 to VTOT-1 and then wraps. vsync_o is active for lines 0 to VSW-1.
- R5: Control bit 3 makes hsync_o active-low and control bit 4 makes vsync_o active-low, each independently of the other.
- R6: Register map, written with wr_en: address 0 is control (bit 0 enable); address 1 holds WIDTH in the low field and HEIGHT in the high field; address 2 holds HTOT and HBP; address 3 holds VTOT and VBP; address 4 holds HSW and VSW. The low field is bits [CW-1:0] and the high field is bits [2CW-1:CW]. While enabled, a write takes effect only after the current field ends. While disabled, it takes effect at once.
- R7: The lead L is computed from the frame line total T and HEIGHT as follows. Start from T-HEIGHT (floored at 0). Halve it if interlace is set. Subtract 2 on the TV channel (floored at 0). Clamp the result to DMAX, which defaults to 30. sof_o is high for exactly one line, starting L lines before the first active line; if that point falls before line 0, it wraps into the previous field.
- R8: On the TV channel in progressive mode (control bit 1 = 1, bit 2 = 0), VTOT is given in half-lines. line_y_o then counts 0 to VTOT/2-1, and VSW, VBP and HEIGHT stay in lines.
- R9: On the TV channel with interlace (control bit 2 = 1), VTOT gives the half-lines per field and the active height per field is HEIGHT/2. field_o toggles at every field wrap. With an odd VTOT, the vsync of field 1 begins at pixel HTOT/2.
- R10: Writes to addresses 5 to 7 change no register and have no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 2*CW | Register write data |
| hsync_o | output | 1 | Horizontal sync, polarity applied |
| vsync_o | output | 1 | Vertical sync, polarity applied |
| de_o | output | 1 | Data enable |
| sof_o | output | 1 | Early start-of-frame pulse |
| field_o | output | 1 | Current field in interlaced TV mode |
| pix_x_o | output | CW | Pixel position in the line |
| line_y_o | output | CW | Line position in the field |
| pins_oe_o | output | 1 | Output drive enable; 0 means tristate |

## Verification
A wrong pixel or unit counter shows up on pix_x_o and line_y_o, and in the hsync, vsync and data-enable edges, within one line of the fault. A live bank loaded at the wrong time changes polarity or geometry in the middle of a field, where it can be seen on the very next line. A wrong lead computation moves the start-of-frame pulse to a different line in the first field that is observed. A bad half-line counter on the TV channel misplaces the second-field vsync by half a line and breaks the field toggle at the next field wrap.

// File: rtl/lrg_pkg.sv
package lrg_pkg;

  localparam int unsigned ADDR_W = 3;

  localparam logic [ADDR_W-1:0] ADR_CTRL   = 3'd0;
  localparam logic [ADDR_W-1:0] ADR_ACTIVE = 3'd1;
  localparam logic [ADDR_W-1:0] ADR_HTIM   = 3'd2;
  localparam logic [ADDR_W-1:0] ADR_VTIM   = 3'd3;
  localparam logic [ADDR_W-1:0] ADR_SYNC   = 3'd4;

  localparam int unsigned CTRL_W = 5;

  // Control word, LSB first: enable, tv channel, interlace, hsync low, vsync low
  typedef struct packed {
    logic vlow;
    logic hlow;
    logic il;
    logic tv;
    logic en;
  } ctrl_t;

endpackage

// File: rtl/lrg_cfg_regs.sv
module lrg_cfg_regs
  import lrg_pkg::*;
#(
  parameter int unsigned CW   = 12,
  parameter int unsigned DMAX = 30,
  parameter int unsigned DW   = $clog2(DMAX + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [2*CW-1:0]   wr_data,
  input  logic              field_end,
  output ctrl_t             ctl,
  output logic [CW-1:0]     width,
  output logic [CW-1:0]     height,
  output logic [CW-1:0]     htot,
  output logic [CW-1:0]     hbp,
  output logic [CW-1:0]     vtot,
  output logic [CW-1:0]     vbp,
  output logic [CW-1:0]     hsw,
  output logic [CW-1:0]     vsw,
  output logic [DW-1:0]     dly
);

  localparam logic [CW:0]   DMAX_W = (CW+1)'(DMAX);
  localparam logic [DW-1:0] DMAX_D = DW'(DMAX);

  // shadow bank
  ctrl_t         sh_ctl, sh_ctl_d;
  logic [CW-1:0] sh_w, sh_w_d, sh_h, sh_h_d;
  logic [CW-1:0] sh_ht, sh_ht_d, sh_hb, sh_hb_d;
  logic [CW-1:0] sh_vt, sh_vt_d, sh_vb, sh_vb_d;
  logic [CW-1:0] sh_hs, sh_hs_d, sh_vs, sh_vs_d;

  logic [CW-1:0] lo_f, hi_f;
  assign lo_f = wr_data[CW-1:0];
  assign hi_f = wr_data[2*CW-1:CW];

  always_comb begin
    sh_ctl_d = sh_ctl;
    sh_w_d   = sh_w;
    sh_h_d   = sh_h;
    sh_ht_d  = sh_ht;
    sh_hb_d  = sh_hb;
    sh_vt_d  = sh_vt;
    sh_vb_d  = sh_vb;
    sh_hs_d  = sh_hs;
    sh_vs_d  = sh_vs;
    if (wr_en) begin
      case (wr_addr)
        ADR_CTRL:   sh_ctl_d = ctrl_t'(lo_f[CTRL_W-1:0]);
        ADR_ACTIVE: begin sh_w_d  = lo_f; sh_h_d  = hi_f; end
        ADR_HTIM:   begin sh_ht_d = lo_f; sh_hb_d = hi_f; end
        ADR_VTIM:   begin sh_vt_d = lo_f; sh_vb_d = hi_f; end
        ADR_SYNC:   begin sh_hs_d = lo_f; sh_vs_d = hi_f; end
        default:    ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_ctl <= '0;
      sh_w   <= '0;
      sh_h   <= '0;
      sh_ht  <= '0;
      sh_hb  <= '0;
      sh_vt  <= '0;
      sh_vb  <= '0;
      sh_hs  <= '0;
      sh_vs  <= '0;
    end else begin
      sh_ctl <= sh_ctl_d;
      sh_w   <= sh_w_d;
      sh_h   <= sh_h_d;
      sh_ht  <= sh_ht_d;
      sh_hb  <= sh_hb_d;
      sh_vt  <= sh_vt_d;
      sh_vb  <= sh_vb_d;
      sh_hs  <= sh_hs_d;
      sh_vs  <= sh_vs_d;
    end
  end

  // lead computation from the shadow values
  logic [CW:0]   tot_lines, blank_a, blank_b, blank_c;
  logic [DW-1:0] dly_d;

  always_comb begin
    tot_lines = (sh_ctl.tv && !sh_ctl.il) ? ({1'b0, sh_vt} >> 1) : {1'b0, sh_vt};
    blank_a   = (tot_lines > {1'b0, sh_h}) ? (tot_lines - {1'b0, sh_h}) : '0;
    blank_b   = sh_ctl.il ? (blank_a >> 1) : blank_a;
    if (sh_ctl.tv) begin
      blank_c = (blank_b > (CW+1)'(2)) ? (blank_b - (CW+1)'(2)) : '0;
    end else begin
      blank_c = blank_b;
    end
    dly_d = (blank_c > DMAX_W) ? DMAX_D : blank_c[DW-1:0];
  end

  // live bank
  logic load;
  assign load = !ctl.en || field_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl    <= '0;
      width  <= '0;
      height <= '0;
      htot   <= '0;
      hbp    <= '0;
      vtot   <= '0;
      vbp    <= '0;
      hsw    <= '0;
      vsw    <= '0;
      dly    <= '0;
    end else if (load) begin
      ctl    <= sh_ctl;
      width  <= sh_w;
      height <= sh_h;
      htot   <= sh_ht;
      hbp    <= sh_hb;
      vtot   <= sh_vt;
      vbp    <= sh_vb;
      hsw    <= sh_hs;
      vsw    <= sh_vs;
      dly    <= dly_d;
    end
  end

  AST_DELAY_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    dly <= DMAX_D); // R7

  AST_HOLD_MIDFIELD: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.en && !field_end) |=> ($stable(ctl) && $stable(htot) && $stable(vtot)
                                && $stable(hbp) && $stable(vbp))); // R6

endmodule

// File: rtl/lrg_hcount.sv
module lrg_hcount #(
  parameter int unsigned CW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          tv,
  input  logic [CW-1:0] htot,
  output logic [CW-1:0] hcnt,
  output logic          line_end,
  output logic          half_tick
);

  logic [CW-1:0] hcnt_d;
  logic [CW-1:0] half_pt;

  assign half_pt   = (htot >> 1) - 1'b1;
  assign line_end  = run && (hcnt >= htot - 1'b1);
  assign half_tick = run && tv && !line_end && (hcnt == half_pt);

  always_comb begin
    if (!run) begin
      hcnt_d = '0;
    end else if (line_end) begin
      hcnt_d = '0;
    end else begin
      hcnt_d = hcnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hcnt <= '0;
    end else begin
      hcnt <= hcnt_d;
    end
  end

  AST_HCNT_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !line_end) |=> (hcnt == $past(hcnt) + 1'b1)); // R2

  AST_HCNT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (hcnt == '0)); // R1

endmodule

// File: rtl/lrg_vcount.sv
module lrg_vcount #(
  parameter int unsigned CW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          tick,
  input  logic          tv,
  input  logic          il,
  input  logic [CW-1:0] vtot,
  output logic [CW-1:0] vcnt,
  output logic          field,
  output logic          field_end
);

  logic [CW-1:0] vcnt_d;
  logic          field_d;
  logic          two_fields;

  assign two_fields = tv && il;
  assign field_end  = tick && (vcnt >= vtot - 1'b1);

  always_comb begin
    vcnt_d  = vcnt;
    field_d = field;
    if (!run) begin
      vcnt_d  = '0;
      field_d = 1'b0;
    end else if (field_end) begin
      vcnt_d  = '0;
      field_d = two_fields ? !field : 1'b0;
    end else if (tick) begin
      vcnt_d  = vcnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vcnt  <= '0;
      field <= 1'b0;
    end else begin
      vcnt  <= vcnt_d;
      field <= field_d;
    end
  end

  AST_FIELD_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    (run && field_end && two_fields) |=> (field != $past(field))); // R9

endmodule

// File: rtl/lrg_out.sv
module lrg_out
  import lrg_pkg::*;
#(
  parameter int unsigned CW = 12,
  parameter int unsigned DW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  ctrl_t         ctl,
  input  logic [CW-1:0] width,
  input  logic [CW-1:0] height,
  input  logic [CW-1:0] hbp,
  input  logic [CW-1:0] vtot,
  input  logic [CW-1:0] vbp,
  input  logic [CW-1:0] hsw,
  input  logic [CW-1:0] vsw,
  input  logic [DW-1:0] dly,
  input  logic [CW-1:0] hcnt,
  input  logic [CW-1:0] vcnt,
  input  logic          field,
  output logic          hsync_o,
  output logic          vsync_o,
  output logic          de_o,
  output logic          sof_o,
  output logic          field_o,
  output logic [CW-1:0] pix_x_o,
  output logic [CW-1:0] line_y_o,
  output logic          pins_oe_o
);

  localparam int unsigned UW = CW + 2;

  logic [CW-1:0] field_h;
  logic [UW-1:0] sync_u, bp_u, act_u, dly_u, sof_u, vcnt_u;
  logic          hs_act, vs_act, h_in, v_in, sof_hit;

  always_comb begin
    field_h = (ctl.tv && ctl.il) ? (height >> 1) : height;
    sync_u  = ctl.tv ? {1'b0, vsw, 1'b0}     : {2'b00, vsw};
    bp_u    = ctl.tv ? {1'b0, vbp, 1'b0}     : {2'b00, vbp};
    act_u   = ctl.tv ? {1'b0, field_h, 1'b0} : {2'b00, field_h};
    dly_u   = ctl.tv ? UW'({dly, 1'b0})      : UW'(dly);
    vcnt_u  = {2'b00, vcnt};
    if (bp_u >= dly_u) begin
      sof_u = bp_u - dly_u;
    end else begin
      sof_u = {2'b00, vtot} - (dly_u - bp_u);
    end
    hs_act  = hcnt < hsw;
    h_in    = ({1'b0, hcnt} >= {1'b0, hbp}) &&
              ({1'b0, hcnt} <  ({1'b0, hbp} + {1'b0, width}));
    vs_act  = vcnt_u < sync_u;
    v_in    = (vcnt_u >= bp_u) && (vcnt_u < (bp_u + act_u));
    sof_hit = (vcnt_u == sof_u) || (ctl.tv && (vcnt_u == sof_u + 1'b1));
  end

  logic          hs_d, vs_d, de_d, sof_d, fld_d, oe_d;
  logic [CW-1:0] pix_d, line_d;

  always_comb begin
    oe_d   = ctl.en;
    hs_d   = ctl.en && (hs_act ^ ctl.hlow);
    vs_d   = ctl.en && (vs_act ^ ctl.vlow);
    de_d   = ctl.en && h_in && v_in;
    sof_d  = ctl.en && sof_hit;
    fld_d  = ctl.en && field;
    pix_d  = ctl.en ? hcnt : '0;
    line_d = ctl.en ? (ctl.tv ? (vcnt >> 1) : vcnt) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hsync_o   <= 1'b0;
      vsync_o   <= 1'b0;
      de_o      <= 1'b0;
      sof_o     <= 1'b0;
      field_o   <= 1'b0;
      pix_x_o   <= '0;
      line_y_o  <= '0;
      pins_oe_o <= 1'b0;
    end else begin
      hsync_o   <= hs_d;
      vsync_o   <= vs_d;
      de_o      <= de_d;
      sof_o     <= sof_d;
      field_o   <= fld_d;
      pix_x_o   <= pix_d;
      line_y_o  <= line_d;
      pins_oe_o <= oe_d;
    end
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !pins_oe_o |-> (!de_o && !sof_o && !hsync_o && !vsync_o && (pix_x_o == '0))); // R1

endmodule

// File: rtl/lcd_raster_gen.sv
module lcd_raster_gen
  import lrg_pkg::*;
#(
  parameter int unsigned CW   = 12,
  parameter int unsigned DMAX = 30
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [2*CW-1:0]   wr_data,
  output logic              hsync_o,
  output logic              vsync_o,
  output logic              de_o,
  output logic              sof_o,
  output logic              field_o,
  output logic [CW-1:0]     pix_x_o,
  output logic [CW-1:0]     line_y_o,
  output logic              pins_oe_o
);

  localparam int unsigned DW = $clog2(DMAX + 1);

  ctrl_t         ctl;
  logic [CW-1:0] width, height, htot, hbp, vtot, vbp, hsw, vsw;
  logic [DW-1:0] dly;
  logic [CW-1:0] hcnt, vcnt;
  logic          line_end, half_tick, field, field_end;

  lrg_cfg_regs #(.CW(CW), .DMAX(DMAX), .DW(DW)) u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .field_end (field_end),
    .ctl       (ctl),
    .width     (width),
    .height    (height),
    .htot      (htot),
    .hbp       (hbp),
    .vtot      (vtot),
    .vbp       (vbp),
    .hsw       (hsw),
    .vsw       (vsw),
    .dly       (dly)
  );

  lrg_hcount #(.CW(CW)) u_hcnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (ctl.en),
    .tv        (ctl.tv),
    .htot      (htot),
    .hcnt      (hcnt),
    .line_end  (line_end),
    .half_tick (half_tick)
  );

  lrg_vcount #(.CW(CW)) u_vcnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (ctl.en),
    .tick      (line_end || half_tick),
    .tv        (ctl.tv),
    .il        (ctl.il),
    .vtot      (vtot),
    .vcnt      (vcnt),
    .field     (field),
    .field_end (field_end)
  );

  lrg_out #(.CW(CW), .DW(DW)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctl       (ctl),
    .width     (width),
    .height    (height),
    .hbp       (hbp),
    .vtot      (vtot),
    .vbp       (vbp),
    .hsw       (hsw),
    .vsw       (vsw),
    .dly       (dly),
    .hcnt      (hcnt),
    .vcnt      (vcnt),
    .field     (field),
    .hsync_o   (hsync_o),
    .vsync_o   (vsync_o),
    .de_o      (de_o),
    .sof_o     (sof_o),
    .field_o   (field_o),
    .pix_x_o   (pix_x_o),
    .line_y_o  (line_y_o),
    .pins_oe_o (pins_oe_o)
  );

endmodule

// File: tb/lcd_raster_gen_tb.sv
module lcd_raster_gen_tb;

  localparam int CW = 12;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          wr_en;
  logic [2:0]    wr_addr;
  logic [2*CW-1:0] wr_data;
  logic          hsync_o, vsync_o, de_o, sof_o, field_o, pins_oe_o;
  logic [CW-1:0] pix_x_o, line_y_o;

  always #2.5 clk = ~clk;

  lcd_raster_gen u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .hsync_o(hsync_o), .vsync_o(vsync_o), .de_o(de_o), .sof_o(sof_o),
    .field_o(field_o), .pix_x_o(pix_x_o), .line_y_o(line_y_o), .pins_oe_o(pins_oe_o)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  // pending and current bench configuration
  int p_tv, p_il, p_hl, p_vl, p_w, p_h, p_ht, p_hb, p_vt, p_vb, p_hs, p_vs;
  int c_tv, c_il, c_hl, c_vl, c_w, c_h, c_ht, c_hb, c_vt, c_vb, c_hs, c_vs;
  // model state
  int m_pix, m_u, m_f;
  bit m_wrapped;
  // tallies
  int e_pos, e_hs, e_vs, e_de, e_sof, e_fld;
  int de_cnt, sof_cnt, flips, max_line, sof_line0;
  int vs_pix_f0, vs_pix_f1;
  logic prev_vs, prev_fld;

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en   = 1'b1;
    wr_addr = 3'(a);
    wr_data = (2*CW)'(d);
    @(negedge clk);
    wr_en   = 1'b0;
  endtask

  function automatic int ctrl_word(input int en);
    return en | (p_tv << 1) | (p_il << 2) | (p_hl << 3) | (p_vl << 4);
  endfunction

  task automatic program_all(input int tv, input int il, input int hl, input int vl,
                             input int w, input int h, input int ht, input int hb,
                             input int vt, input int vb, input int hs, input int vs);
    p_tv = tv; p_il = il; p_hl = hl; p_vl = vl; p_w = w; p_h = h;
    p_ht = ht; p_hb = hb; p_vt = vt; p_vb = vb; p_hs = hs; p_vs = vs;
    wr(1, (h << CW) | w);
    wr(2, (hb << CW) | ht);
    wr(3, (vb << CW) | vt);
    wr(4, (vs << CW) | hs);
    wr(0, ctrl_word(1));
  endtask

  function automatic int lead_lines();
    int tl, b;
    tl = (c_tv != 0 && c_il == 0) ? c_vt / 2 : c_vt;
    b  = (tl > c_h) ? tl - c_h : 0;
    if (c_il != 0) b = b / 2;
    if (c_tv != 0) b = (b > 2) ? b - 2 : 0;
    return (b > 30) ? 30 : b;
  endfunction

  task automatic clear_tallies();
    e_pos = 0; e_hs = 0; e_vs = 0; e_de = 0; e_sof = 0; e_fld = 0;
    de_cnt = 0; sof_cnt = 0; flips = 0; max_line = 0; sof_line0 = -1;
    vs_pix_f0 = -1; vs_pix_f1 = -1; prev_vs = 1'b0; prev_fld = 1'b0;
  endtask

  task automatic cmp_one();
    int syncu, bpu, hf, actu, du, su, eline;
    bit ehs, evs, ede, esof;
    syncu = c_tv != 0 ? 2 * c_vs : c_vs;
    bpu   = c_tv != 0 ? 2 * c_vb : c_vb;
    hf    = (c_tv != 0 && c_il != 0) ? c_h / 2 : c_h;
    actu  = c_tv != 0 ? 2 * hf : hf;
    du    = c_tv != 0 ? 2 * lead_lines() : lead_lines();
    su    = (bpu >= du) ? bpu - du : c_vt - (du - bpu);
    eline = c_tv != 0 ? m_u / 2 : m_u;
    ehs   = (m_pix < c_hs) ^ (c_hl != 0);
    evs   = (m_u < syncu) ^ (c_vl != 0);
    ede   = (m_pix >= c_hb) && (m_pix < c_hb + c_w) && (m_u >= bpu) && (m_u < bpu + actu);
    esof  = (m_u == su) || (c_tv != 0 && m_u == su + 1);
    if (int'(pix_x_o) != m_pix || int'(line_y_o) != eline || pins_oe_o !== 1'b1) e_pos++;
    if (hsync_o !== ehs) e_hs++;
    if (vsync_o !== evs) e_vs++;
    if (de_o !== ede) e_de++;
    if (sof_o !== esof) e_sof++;
    if (int'(field_o) != m_f) e_fld++;
    if (de_o === 1'b1) de_cnt++;
    if (sof_o === 1'b1) begin
      sof_cnt++;
      if (sof_line0 < 0) sof_line0 = int'(line_y_o);
    end
    if (int'(line_y_o) > max_line) max_line = int'(line_y_o);
    if (field_o !== prev_fld) flips++;
    if (vsync_o === 1'b1 && prev_vs === 1'b0) begin
      if (field_o === 1'b1) vs_pix_f1 = int'(pix_x_o);
      else vs_pix_f0 = int'(pix_x_o);
    end
    prev_vs  = vsync_o;
    prev_fld = field_o;
  endtask

  task automatic step_model();
    bit tick;
    tick = (m_pix == c_ht - 1) || (c_tv != 0 && m_pix == c_ht / 2 - 1);
    m_pix = (m_pix == c_ht - 1) ? 0 : m_pix + 1;
    m_wrapped = 1'b0;
    if (tick) begin
      if (m_u == c_vt - 1) begin
        m_u = 0;
        m_f = (c_tv != 0 && c_il != 0) ? 1 - m_f : 0;
        c_tv = p_tv; c_il = p_il; c_hl = p_hl; c_vl = p_vl; c_w = p_w; c_h = p_h;
        c_ht = p_ht; c_hb = p_hb; c_vt = p_vt; c_vb = p_vb; c_hs = p_hs; c_vs = p_vs;
        m_wrapped = 1'b1;
      end else begin
        m_u++;
      end
    end
  endtask

  task automatic start_model();
    int guard = 0;
    @(negedge clk);
    while (pins_oe_o !== 1'b1 && guard < 100) begin
      @(negedge clk);
      guard++;
    end
    c_tv = p_tv; c_il = p_il; c_hl = p_hl; c_vl = p_vl; c_w = p_w; c_h = p_h;
    c_ht = p_ht; c_hb = p_hb; c_vt = p_vt; c_vb = p_vb; c_hs = p_hs; c_vs = p_vs;
    m_pix = 0; m_u = 0; m_f = 0;
    clear_tallies();
  endtask

  task automatic mon(input int n);
    for (int i = 0; i < n; i++) begin
      cmp_one();
      step_model();
      @(negedge clk);
    end
  endtask

  task automatic mon_to_wrap();
    m_wrapped = 1'b0;
    for (int i = 0; i < 5000 && !m_wrapped; i++) begin
      cmp_one();
      step_model();
      @(negedge clk);
    end
  endtask

  task automatic idle_check(input string req);
    int bad = 0;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if ({pins_oe_o, hsync_o, vsync_o, de_o, sof_o, field_o} !== 6'b0 ||
          pix_x_o !== '0 || line_y_o !== '0) bad++;
    end
    chk(req, "idle outputs nonzero cycles", bad, 0);
  endtask

  task automatic stop_gen();
    int lat = 0;
    wr(0, ctrl_word(0));
    while (pins_oe_o === 1'b1 && lat < 3000) begin
      @(negedge clk);
      lat++;
    end
    chk("R6", "disable deferred to field end (latency>0)", int'(lat > 0), 1);
    idle_check("R1");
  endtask

  task automatic t_reset();
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    repeat (4) @(posedge clk);
    idle_check("R1");
    @(negedge clk);
    rst_n = 1'b1;
    idle_check("R1");
  endtask

  task automatic t_lcd();
    program_all(0, 0, 0, 0, 8, 4, 16, 4, 10, 3, 2, 1);
    start_model();
    mon(320);
    chk("R2", "pixel/line sequence errors", e_pos, 0);
    chk("R2", "hsync errors", e_hs, 0);
    chk("R4", "vsync errors", e_vs, 0);
    chk("R4", "highest line", max_line, 9);
    chk("R3", "de errors", e_de, 0);
    chk("R3", "de cycles over two fields", de_cnt, 64);
    chk("R7", "sof errors", e_sof, 0);
    chk("R7", "sof cycles over two fields", sof_cnt, 32);
    chk("R7", "sof line", sof_line0, 7);
  endtask

  task automatic t_polarity();
    int pre;
    mon(40);
    p_hl = 1; p_vl = 1;
    fork
      wr(0, ctrl_word(1));
      mon(2);
    join
    mon_to_wrap();
    pre = e_hs + e_vs;
    chk("R6", "polarity changed before field end", pre, 0);
    chk("R5", "hsync low at pixel 0 of new field", int'(hsync_o), 0);
    chk("R5", "vsync low at line 0 of new field", int'(vsync_o), 0);
    mon(200);
    chk("R5", "inverted sync errors", e_hs + e_vs - pre, 0);
  endtask

  task automatic t_bad_addr();
    clear_tallies();
    fork
      begin wr(5, -1); wr(6, -1); wr(7, -1); end
      mon(6);
    join
    mon(330);
    chk("R10", "deviation after unmapped writes",
        e_pos + e_hs + e_vs + e_de + e_sof + e_fld, 0);
  endtask

  task automatic t_clamp();
    program_all(0, 0, 0, 0, 8, 4, 16, 4, 60, 3, 2, 1);
    start_model();
    mon(960);
    chk("R7", "sof errors with clamp", e_sof, 0);
    chk("R7", "sof line with clamp", sof_line0, 33);
    chk("R7", "sof cycles one line", sof_cnt, 16);
    chk("R3", "de errors", e_de, 0);
  endtask

  task automatic t_tv_prog();
    program_all(1, 0, 0, 0, 8, 4, 16, 4, 20, 3, 2, 1);
    start_model();
    mon(320);
    chk("R8", "position errors", e_pos, 0);
    chk("R8", "highest line", max_line, 9);
    chk("R8", "vsync errors", e_vs, 0);
    chk("R8", "de cycles", de_cnt, 64);
    chk("R7", "sof line tv", sof_line0, 9);
    chk("R7", "sof errors tv", e_sof, 0);
  endtask

  task automatic t_tv_il();
    program_all(1, 1, 0, 0, 8, 8, 16, 4, 21, 3, 2, 1);
    start_model();
    mon(504);
    chk("R9", "field flips", flips, 2);
    chk("R9", "field errors", e_fld, 0);
    chk("R9", "vsync start pixel field 0", vs_pix_f0, 0);
    chk("R9", "vsync start pixel field 1", vs_pix_f1, 8);
    chk("R9", "de cycles over three fields", de_cnt, 96);
    chk("R9", "de/vsync/sof errors", e_de + e_vs + e_sof + e_pos, 0);
  endtask

  initial begin
    t_reset();
    t_lcd();
    t_polarity();
    t_bad_addr();
    stop_gen();
    t_clamp();
    stop_gen();
    t_tv_prog();
    stop_gen();
    t_tv_il();
    stop_gen();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule